// File: doc/BRIEF.md
# Split-Write Transmit Word Stager

This block builds one 32-bit transmit word for a serial avionics data bus out of two 16-bit host register writes, and offers the finished word to a serial transmitter for a single, unscheduled send. The host places the upper half-word at one register offset, then the lower half-word at a second offset. The lower write is the commit point. It latches the full word into a staging register and raises a word-pending status bit that the host can read.

The transmitter takes the staged word through a valid/ready handshake, and that acceptance clears the pending status. Both half-word registers can be read back at their own offsets. An upper write by itself stays in its holding register and never starts a send. A lower write that arrives while a word is still pending replaces the pending word in place. Serial encoding, periodic transmit schedules and parity are handled elsewhere.

Top module: `split_tx_stager`

## Requirements
- R1: After reset, both half-word registers read 0, `tx_valid` is low and `avail_stat` is low.
- R2: A write at offset 0xFC (upper half) stores `bus_wdata`. A read at 0xFC returns the last value written there.
- R3: A write at offset 0xFE (lower half) stores `bus_wdata`. A read at 0xFE returns the last value written there.
- R4: A write at 0xFE commits a word to `tx_word`. Bits 31:16 are the upper register and bits 15:0 are the written data. From the next cycle, `tx_valid` and `avail_stat` are high.
- R5: An upper-half write with no later lower-half write never raises `tx_valid` or `avail_stat`.
- R6: An upper-half write while a word is pending leaves `tx_word` unchanged. The new upper value is used by the next commit.
- R7: A cycle with `tx_valid` and `tx_ready` both high clears `tx_valid` and `avail_stat` on the next cycle, unless a lower-half write happens in that same cycle.
- R8: A lower-half write while a word is pending replaces the staged word, and `tx_valid`/`avail_stat` stay high.
- R9: `tx_word` changes only on a lower-half write. It is held unchanged while the word waits for `tx_ready`.
- R10: A write to any other offset changes no state. A read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host register offset |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tx_word | output | 32 | Staged word toward the transmitter |
| tx_valid | output | 1 | Staged word is pending |
| tx_ready | input | 1 | Transmitter accepts the word |
| avail_stat | output | 1 | Host-readable word-pending status |

## Verification
The fault classes and when they become visible:
- **Stuck pending flag:** `tx_valid` and `avail_stat` disagree with the model in the first cycle after the write or the accept that should have moved the flag.
- **Wrong staged word:** a wrong concatenation, or a commit on the upper write, shows on `tx_word` one cycle after the commit.
- **Corrupted holding register:** this may stay hidden until the next commit, so every cycle also reads back one of the offsets through `bus_rdata`.

Each cycle, the bench compares every output against a behavioural model, so any difference is reported in the cycle it appears.

// File: rtl/stg_pkg.sv
package stg_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } sel_e;
endpackage

// File: rtl/stg_decode.sv
module stg_decode
    import stg_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [7:0]  HI_OFS = 8'hFC,
    parameter logic [7:0]  LO_OFS = 8'hFE
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_OFS);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_OFS);

    always_comb begin
        if (addr == HI_A)      sel = SEL_HI;
        else if (addr == LO_A) sel = SEL_LO;
        else                   sel = SEL_NONE;
    end
endmodule

// File: rtl/stg_halfregs.sv
module stg_halfregs
    import stg_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  sel_e              sel,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic [HALF_W-1:0] hi_val
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr && sel == SEL_HI) regs_d.hi = wdata;
        if (wr && sel == SEL_LO) regs_d.lo = wdata;
        unique case (sel)
            SEL_HI:  rdata = regs_q.hi;
            SEL_LO:  rdata = regs_q.lo;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign hi_val = regs_q.hi;

    // R2
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_HI) |=> $stable(regs_q.hi));
    // R3
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_LO) |=> $stable(regs_q.lo));
endmodule

// File: rtl/stg_commit.sv
module stg_commit #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [HALF_W-1:0]   hi_in,
    input  logic [HALF_W-1:0]   lo_in,
    input  logic                tx_ready,
    output logic [2*HALF_W-1:0] word,
    output logic                pend
);
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pend;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend && tx_ready) st_d.pend = 1'b0;
        if (commit) begin
            st_d.word = {hi_in, lo_in};
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;
    assign pend = st_q.pend;

    // R4 R8
    commit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> st_q.pend);
    // R7
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && tx_ready && !commit) |=> !st_q.pend);
    // R5
    no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && !commit) |=> !st_q.pend);
    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.word));
endmodule

// File: rtl/split_tx_stager.sv
module split_tx_stager
    import stg_pkg::*;
#(
    parameter int         HALF_W = 16,
    parameter int         ADDR_W = 8,
    parameter logic [7:0] HI_OFS = 8'hFC,
    parameter logic [7:0] LO_OFS = 8'hFE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HALF_W-1:0]   bus_wdata,
    output logic [HALF_W-1:0]   bus_rdata,
    output logic [2*HALF_W-1:0] tx_word,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic                avail_stat
);
    sel_e              sel;
    logic [HALF_W-1:0] hi_val;
    logic              pend;
    logic              commit;

    stg_decode #(.ADDR_W(ADDR_W), .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    stg_halfregs #(.HALF_W(HALF_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .hi_val(hi_val)
    );

    assign commit = bus_wr && (sel == SEL_LO);

    stg_commit #(.HALF_W(HALF_W)) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .hi_in   (hi_val),
        .lo_in   (bus_wdata),
        .tx_ready(tx_ready),
        .word    (tx_word),
        .pend    (pend)
    );

    assign tx_valid   = pend;
    assign avail_stat = pend;

    // R10
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/split_tx_stager_test.sv
module split_tx_stager_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_HI = 8'hFC;
    localparam logic [7:0] A_LO = 8'hFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [31:0] tx_word;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        avail_stat;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [15:0] m_hi = 16'h0;
    logic [15:0] m_lo = 16'h0;
    logic [31:0] m_word = 32'h0;
    logic        m_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_tx_stager uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_word(tx_word),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .avail_stat(avail_stat)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive one cycle at negedge, compare outputs, then advance model at posedge
    task automatic cyc(input logic wr, input logic [7:0] addr,
                       input logic [15:0] d, input logic rdy, input string tag);
        logic [15:0] exp_rd;
        bus_wr = wr; bus_addr = addr; bus_wdata = d; tx_ready = rdy;
        #1;
        exp_rd = (addr == A_HI) ? m_hi : (addr == A_LO) ? m_lo : 16'h0;
        check(tag, "bus_rdata", {16'h0, bus_rdata}, {16'h0, exp_rd});
        check(tag, "tx_valid", {31'h0, tx_valid}, {31'h0, m_pend});
        check(tag, "avail_stat", {31'h0, avail_stat}, {31'h0, m_pend});
        check(tag, "tx_word", tx_word, m_word);
        @(posedge clk);
        if (m_pend && rdy) m_pend = 1'b0;
        if (wr && addr == A_HI) m_hi = d;
        if (wr && addr == A_LO) begin
            m_lo = d;
            m_word = {m_hi, d};
            m_pend = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values seen while reset is held
        #1;
        check("R1", "tx_valid in reset", {31'h0, tx_valid}, 32'h0);
        check("R1", "avail in reset", {31'h0, avail_stat}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(0, A_HI, 16'h0, 0, "R1");
        cyc(0, A_LO, 16'h0, 0, "R1");

        // R5 upper write alone never sends
        cyc(1, A_HI, 16'hA5C3, 1, "R5");
        for (int i = 0; i < 5; i++) cyc(0, A_HI, 16'h0, 1, "R5");
        cyc(0, A_HI, 16'h0, 0, "R2");

        // R4 commit, R9 hold while not ready, R3 readback
        cyc(1, A_LO, 16'h1234, 0, "R4");
        for (int i = 0; i < 4; i++) cyc(0, A_LO, 16'h0, 0, "R9");
        cyc(0, A_LO, 16'h0, 0, "R3");

        // R6 upper write while pending
        cyc(1, A_HI, 16'hBEEF, 0, "R6");
        cyc(0, A_HI, 16'h0, 0, "R6");
        // R7 accept clears
        cyc(0, 8'h00, 16'h0, 1, "R7");
        cyc(0, 8'h00, 16'h0, 1, "R7");
        cyc(1, A_LO, 16'h0042, 0, "R6");
        cyc(0, A_LO, 16'h0, 0, "R6");

        // R8 overwrite while pending
        cyc(1, A_HI, 16'h7777, 0, "R8");
        cyc(1, A_LO, 16'h8888, 0, "R8");
        cyc(1, A_LO, 16'h9999, 0, "R8");
        cyc(0, A_LO, 16'h0, 0, "R8");
        // R7 accept coincident with new commit keeps pending
        cyc(1, A_LO, 16'hCAFE, 1, "R7");
        cyc(0, A_LO, 16'h0, 0, "R7");
        cyc(0, A_LO, 16'h0, 1, "R7");
        cyc(0, A_LO, 16'h0, 0, "R7");

        // R10 other offsets
        cyc(1, 8'h10, 16'hFFFF, 0, "R10");
        cyc(1, 8'hFD, 16'h5555, 0, "R10");
        cyc(0, 8'hFD, 16'h0, 0, "R10");
        cyc(0, A_HI, 16'h0, 0, "R10");
        cyc(0, A_LO, 16'h0, 0, "R10");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic [7:0] addr;
            a = 2'($urandom_range(0, 3));
            addr = (a == 0) ? A_HI : (a == 1) ? A_LO : (a == 2) ? 8'h20 : A_LO;
            cyc(1'($urandom_range(0, 1)), addr, 16'($urandom),
                1'($urandom_range(0, 1)), "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule